// File: doc/BRIEF.md
# Prescaled Real-Time Match Counter

This block keeps time by counting a crystal-derived clock. An internal prescaler divides that clock by 128. Each prescaler wrap advances a 40-bit counter. Software can preload the counter, read it back coherently, and program a 40-bit compare value. While the count equals the compare value, two identical match pins are high. One pin serves general logic and the other serves a power-sequencing consumer. A sticky all-ones status register records that a match occurred. An optional mode returns the counter to zero after a match, unless the compare value is zero.

Software reaches the block through a byte-wide register port, one byte per address. A control byte holds the auto-clear enable and drives a 2-bit crystal-mode output and a crystal-enable output toward the oscillator. The register port and the counter share the same clock.

Top module: `rtmc_top`

## Requirements
- R1: The counter advances by one every 128 clocks; after a commit it first increments on the 128th following edge.
- R2: Writes to count bytes at addresses 0..3 only stage data. A write to address 4 loads {that byte, staged bytes 3..0} into the counter and restarts the prescaler. A load wins over an increment that falls in the same cycle.
- R3: A read of address 0 returns the live low count byte and captures all 40 bits into a hold register. Reads of addresses 1..4 return bytes 1..4 of that held copy, which changes only on an address-0 read.
- R4: Both match pins are high exactly while the count equals the compare register (addresses 5..9, byte 0 at address 5), with no register stage in between.
- R5: The status register at addresses 10..14 reads 0xFF in every byte from the clock after equality begins. A write of any data to any of these addresses clears it to zero. A set wins over a clear in the same cycle.
- R6: With auto-clear enabled, the increment that would follow a matching count loads zero instead, so the pins stay high for one full prescaled period.
- R7: With a compare value of zero, auto-clear has no effect and the counter keeps incrementing.
- R8: The control byte is at address 15: bit 0 is auto-clear enable, bits 2:1 drive the crystal-mode output, bit 3 drives the crystal-enable output, and bits 7:4 read as zero.
- R9: After reset, the count, compare, status and control registers are zero. Both match pins are therefore high, and the crystal outputs are low.
- R10: Read data appears on the clock after the read strobe and holds until the next read. Writes change the register in the write cycle's edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-derived clock for the counter and the register port |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 4 | Byte address of the register access |
| regWe | input | 1 | Write strobe |
| regRe | input | 1 | Read strobe |
| regWdata | input | 8 | Write data byte |
| regRdata | output | 8 | Read data byte, one cycle after the read strobe |
| matchFabric | output | 1 | High while count equals compare value |
| matchSeq | output | 1 | Same as matchFabric, for the power-sequencing consumer |
| xtalMode | output | 2 | Crystal-mode field from the control byte |
| xtalEnable | output | 1 | Crystal-enable bit from the control byte |

## Verification
Two pairs of functions can collide in one cycle. A software load of the counter can land on the edge where the prescaler wraps, and a clear of the status register can land on the edge where equality first sets it. The bench times the top-byte write so that its edge is the 128th after an earlier load. It then expects the loaded value rather than that value plus one, and the next increment a full period later. In the second case it writes the status register on the edge right after the count reaches the compare value, and expects the status still to read 0xFF.

// File: rtl/rtmc_pkg.sv
package rtmc_pkg;
  localparam int CNT_W      = 40;
  localparam int BYTE_N     = CNT_W / 8;
  localparam int SEL_W      = $clog2(BYTE_N);
  localparam int MATCH_BASE = BYTE_N;
  localparam int BITS_BASE  = 2 * BYTE_N;
  localparam int CTRL_ADDR  = 3 * BYTE_N;
  localparam int ADDR_W     = $clog2(CTRL_ADDR + 1);

  typedef enum logic [2:0] {
    RG_CNT, RG_MATCH, RG_BITS, RG_CTRL, RG_NONE
  } region_e;

  typedef struct packed {
    logic             stageWe;
    logic             commit;
    logic             snap;
    logic             matchWe;
    logic             bitsClr;
    logic             ctrlWe;
    logic             rdEn;
    region_e          region;
    logic [SEL_W-1:0] byteSel;
  } strobe_t;
endpackage

// File: rtl/rtmc_ctrl.sv
module rtmc_ctrl
  import rtmc_pkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic              regRe,
  output strobe_t           stb
);
  logic [ADDR_W-1:0] offs;
  region_e           region;
  logic              lastByte;

  // address decode into a region and a byte lane
  always_comb begin
    if (regAddr < ADDR_W'(MATCH_BASE)) begin
      region = RG_CNT;
      offs   = regAddr;
    end else if (regAddr < ADDR_W'(BITS_BASE)) begin
      region = RG_MATCH;
      offs   = regAddr - ADDR_W'(MATCH_BASE);
    end else if (regAddr < ADDR_W'(CTRL_ADDR)) begin
      region = RG_BITS;
      offs   = regAddr - ADDR_W'(BITS_BASE);
    end else if (regAddr == ADDR_W'(CTRL_ADDR)) begin
      region = RG_CTRL;
      offs   = '0;
    end else begin
      region = RG_NONE;
      offs   = '0;
    end
  end

  assign lastByte = (offs == ADDR_W'(BYTE_N - 1));

  always_comb begin
    stb         = '0;
    stb.region  = region;
    stb.byteSel = SEL_W'(offs);
    stb.rdEn    = regRe;
    stb.stageWe = regWe && (region == RG_CNT) && !lastByte;
    stb.commit  = regWe && (region == RG_CNT) && lastByte;
    stb.snap    = regRe && (region == RG_CNT) && (offs == '0);
    stb.matchWe = regWe && (region == RG_MATCH);
    stb.bitsClr = regWe && (region == RG_BITS);
    stb.ctrlWe  = regWe && (region == RG_CTRL);
  end
endmodule

// File: rtl/rtmc_dpath.sv
module rtmc_dpath
  import rtmc_pkg::*;
#(
  parameter  int PRE_DIV = 128,
  localparam int PRE_W   = $clog2(PRE_DIV)
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  output logic [CNT_W-1:0] countVal,
  output logic [CNT_W-1:0] matchVal,
  output logic [CNT_W-1:0] bitsVal,
  output logic [CNT_W-1:0] holdVal,
  output logic             tick,
  output logic             hit,
  output logic             autoClr,
  output logic [1:0]       xtalMode,
  output logic             xtalEnable
);
  localparam int STAGE_W = CNT_W - 8;

  logic [PRE_W-1:0]   preCnt;
  logic [7:0]         stageLane [BYTE_N-1];
  logic [7:0]         matchLane [BYTE_N];
  logic [STAGE_W-1:0] stageVal;
  logic               hitPrev;
  logic               bitsFlag;
  logic               clearOk;

  // prescaler: wraps every PRE_DIV clocks, restarts on a counter load
  assign tick = (preCnt == PRE_W'(PRE_DIV - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           preCnt <= '0;
    else if (stb.commit) preCnt <= '0;
    else if (tick)       preCnt <= '0;
    else                 preCnt <= preCnt + PRE_W'(1);
  end

  // per-lane staging and compare registers
  for (genvar b = 0; b < BYTE_N - 1; b++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        stageLane[b] <= '0;
      else if (stb.stageWe && stb.byteSel == SEL_W'(b))
        stageLane[b] <= wdata;
    end
    assign stageVal[b*8 +: 8] = stageLane[b];
  end

  for (genvar b = 0; b < BYTE_N; b++) begin : g_match
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        matchLane[b] <= '0;
      else if (stb.matchWe && stb.byteSel == SEL_W'(b))
        matchLane[b] <= wdata;
    end
    assign matchVal[b*8 +: 8] = matchLane[b];
  end

  // main counter
  assign hit     = (countVal == matchVal);
  assign clearOk = autoClr && hit && (matchVal != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      countVal <= '0;
    else if (stb.commit)
      countVal <= {wdata, stageVal};
    else if (tick)
      countVal <= clearOk ? '0 : countVal + CNT_W'(1);
  end

  // sticky match record, set on the first cycle of equality
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitPrev  <= 1'b1;
      bitsFlag <= 1'b0;
    end else begin
      hitPrev <= hit;
      if (hit && !hitPrev) bitsFlag <= 1'b1;
      else if (stb.bitsClr) bitsFlag <= 1'b0;
    end
  end
  assign bitsVal = {CNT_W{bitsFlag}};

  // read snapshot
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         holdVal <= '0;
    else if (stb.snap) holdVal <= countVal;
  end

  // control byte
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      autoClr    <= 1'b0;
      xtalMode   <= 2'b00;
      xtalEnable <= 1'b0;
    end else if (stb.ctrlWe) begin
      autoClr    <= wdata[0];
      xtalMode   <= wdata[2:1];
      xtalEnable <= wdata[3];
    end
  end

  // registered read mux
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdata <= '0;
    end else if (stb.rdEn) begin
      case (stb.region)
        RG_CNT:   rdata <= (stb.byteSel == '0) ? countVal[7:0]
                                               : holdVal[int'(stb.byteSel)*8 +: 8];
        RG_MATCH: rdata <= matchLane[stb.byteSel];
        RG_BITS:  rdata <= {8{bitsFlag}};
        RG_CTRL:  rdata <= {4'b0000, xtalEnable, xtalMode, autoClr};
        default:  rdata <= 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/rtmc_top.sv
module rtmc_top
  import rtmc_pkg::*;
#(
  parameter int PRE_DIV = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic              regRe,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  output logic              matchFabric,
  output logic              matchSeq,
  output logic [1:0]        xtalMode,
  output logic              xtalEnable
);
  strobe_t          stb;
  logic [CNT_W-1:0] countVal;
  logic [CNT_W-1:0] matchVal;
  logic [CNT_W-1:0] bitsVal;
  logic [CNT_W-1:0] holdVal;
  logic             tick;
  logic             hit;
  logic             autoClr;

  rtmc_ctrl ctrl_i (
    .regAddr (regAddr),
    .regWe   (regWe),
    .regRe   (regRe),
    .stb     (stb)
  );

  rtmc_dpath #(.PRE_DIV(PRE_DIV)) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wdata      (regWdata),
    .rdata      (regRdata),
    .countVal   (countVal),
    .matchVal   (matchVal),
    .bitsVal    (bitsVal),
    .holdVal    (holdVal),
    .tick       (tick),
    .hit        (hit),
    .autoClr    (autoClr),
    .xtalMode   (xtalMode),
    .xtalEnable (xtalEnable)
  );

  assign matchFabric = hit;
  assign matchSeq    = hit;
endmodule

// File: rtl/rtmc_chk.sv
module rtmc_chk
  import rtmc_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             matchFabric,
  input logic             tick,
  input logic             autoClr,
  input logic             commit,
  input logic             snap,
  input logic             ctrlWe,
  input logic             bitsClr,
  input logic [7:0]       regWdata,
  input logic [CNT_W-1:0] countVal,
  input logic [CNT_W-1:0] matchVal,
  input logic [CNT_W-1:0] bitsVal,
  input logic [CNT_W-1:0] holdVal,
  input logic [1:0]       xtalMode
);
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    tick && !commit && !(autoClr && matchFabric && matchVal != '0) |=> countVal == $past(countVal) + CNT_W'(1)); // R1
  AST_LOAD_TOP: assert property (@(posedge clk) disable iff (!rstN)
    commit |=> countVal[CNT_W-1 -: 8] == $past(regWdata)); // R2
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !snap |=> $stable(holdVal)); // R3
  AST_BITS_SET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(matchFabric) |=> bitsVal == '1); // R5
  AST_BITS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !bitsClr && bitsVal == '1 |=> bitsVal == '1); // R5
  AST_AUTO_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    tick && !commit && autoClr && matchFabric && matchVal != '0 |=> countVal == '0); // R6
  AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    tick && !commit && matchVal == '0 |=> countVal == $past(countVal) + CNT_W'(1)); // R7
  AST_MODE_PIN: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWe |=> xtalMode == $past(regWdata[2:1])); // R8
endmodule

bind rtmc_top rtmc_chk chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .matchFabric (matchFabric),
  .tick        (tick),
  .autoClr     (autoClr),
  .commit      (stb.commit),
  .snap        (stb.snap),
  .ctrlWe      (stb.ctrlWe),
  .bitsClr     (stb.bitsClr),
  .regWdata    (regWdata),
  .countVal    (countVal),
  .matchVal    (matchVal),
  .bitsVal     (bitsVal),
  .holdVal     (holdVal),
  .xtalMode    (xtalMode)
);

// File: tb/rtmc_top_tb_top.sv
module rtmc_top_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] regAddr = '0;
  logic       regWe = 1'b0;
  logic       regRe = 1'b0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       matchFabric, matchSeq, xtalEnable;
  logic [1:0] xtalMode;

  int   total = 0;
  int   bad = 0;
  int   cyc = 0;
  int   t0 = 0;
  int   t1 = 0;
  logic reSeen = 1'b0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #5 clk = ~clk;

  rtmc_top dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe), .regRe(regRe),
    .regWdata(regWdata), .regRdata(regRdata), .matchFabric(matchFabric),
    .matchSeq(matchSeq), .xtalMode(xtalMode), .xtalEnable(xtalEnable)
  );

  always @(posedge clk) begin
    cyc    <= cyc + 1;
    reSeen <= regRe;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected byte for each completed read
  always @(negedge clk) begin
    if (reSeen) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R10 unexpected read data", {56'd0, regRdata}, 64'd0);
      end else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(regRdata === e, t, {56'd0, regRdata}, {56'd0, e});
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
    regAddr = a; regRe = 1'b1;
    expQ.push_back(e); tagQ.push_back(t);
    @(negedge clk);
    regRe = 1'b0;
  endtask

  task automatic preload(input logic [39:0] v);
    for (int i = 0; i < 5; i++) wr(4'(i), v[i*8 +: 8]);
    t0 = cyc;
  endtask

  task automatic waitTo(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(matchFabric && matchSeq, "R9 match pins after reset", {63'd0, matchFabric}, 64'd1);
    chk(xtalMode == 2'b00 && !xtalEnable, "R9 crystal pins after reset", {61'd0, xtalEnable, xtalMode}, 64'd0);
    rd(4'd15, 8'h00, "R9 control reads zero");
    rd(4'd10, 8'h00, "R9 status reads zero");
    rd(4'd0,  8'h00, "R9 count reads zero");

    // R8 control byte to pins
    wr(4'd15, 8'h0C);
    chk(xtalMode == 2'd2 && xtalEnable, "R8 crystal pins", {61'd0, xtalEnable, xtalMode}, 64'h6);
    rd(4'd15, 8'h0C, "R8 control readback");

    // R2/R3 preload and byte reads
    preload(40'h12_3456_789A);
    chk(!matchFabric && !matchSeq, "R4 pins low when unequal", {63'd0, matchFabric}, 64'd0);
    rd(4'd0, 8'h9A, "R3 byte0");
    rd(4'd1, 8'h78, "R3 byte1");
    rd(4'd2, 8'h56, "R3 byte2");
    rd(4'd3, 8'h34, "R3 byte3");
    rd(4'd4, 8'h12, "R2 byte4");

    // R3 coherent snapshot across a carry
    preload(40'h00_FFFF_FFFF);
    waitTo(t0 + 126);
    rd(4'd0, 8'hFF, "R3 snap byte0");
    rd(4'd1, 8'hFF, "R3 held byte1");
    rd(4'd2, 8'hFF, "R3 held byte2");
    rd(4'd3, 8'hFF, "R3 held byte3");
    rd(4'd4, 8'h00, "R3 held byte4");
    rd(4'd0, 8'h00, "R1 low byte after carry");
    rd(4'd4, 8'h01, "R1 top byte after carry");

    // R1 rate
    preload(40'h10);
    waitTo(t0 + 390);
    rd(4'd0, 8'h13, "R1 three increments");

    // R2 load restarts the prescaler, and load beats increment
    preload(40'h40);
    waitTo(t0 + 60);
    preload(40'h50);
    t1 = t0;
    waitTo(t1 + 100);
    rd(4'd0, 8'h50, "R2 prescaler restarted");
    waitTo(t1 + 127);
    wr(4'd4, 8'h00);
    t1 = cyc;
    rd(4'd0, 8'h50, "R2 load wins over increment");
    waitTo(t1 + 129);
    rd(4'd0, 8'h51, "R2 period after load");

    // R4/R5 match pins and status
    wr(4'd5, 8'h21);
    for (int i = 6; i < 10; i++) wr(4'(i), 8'h00);
    preload(40'h20);
    wr(4'd10, 8'h00);
    waitTo(t0 + 128);
    chk(matchFabric && matchSeq, "R4 pins high on equality", {63'd0, matchFabric}, 64'd1);
    waitTo(t0 + 132);
    rd(4'd12, 8'hFF, "R5 status set");
    rd(4'd10, 8'hFF, "R5 status set byte0");
    rd(4'd5,  8'h21, "R10 compare readback");
    waitTo(t0 + 256);
    chk(!matchFabric && !matchSeq, "R4 pins low after count moves", {63'd0, matchFabric}, 64'd0);
    rd(4'd14, 8'hFF, "R5 status sticky");
    wr(4'd13, 8'h5A);
    rd(4'd11, 8'h00, "R5 any write clears");

    // R5 set wins over clear
    wr(4'd5, 8'h31);
    preload(40'h30);
    wr(4'd10, 8'h00);
    waitTo(t0 + 128);
    wr(4'd11, 8'h00);
    rd(4'd10, 8'hFF, "R5 set beats clear");

    // R6 auto-clear
    wr(4'd15, 8'h0D);
    wr(4'd5, 8'h06);
    preload(40'h05);
    waitTo(t0 + 200);
    chk(matchFabric, "R6 pins held for full period", {63'd0, matchFabric}, 64'd1);
    waitTo(t0 + 256);
    chk(!matchFabric, "R6 pins drop after clear", {63'd0, matchFabric}, 64'd0);
    rd(4'd0, 8'h00, "R6 counter cleared");
    waitTo(t0 + 385);
    rd(4'd0, 8'h01, "R6 counts on from zero");

    // R7 zero compare suppresses auto-clear
    wr(4'd5, 8'h00);
    preload(40'h00);
    chk(matchFabric, "R7 equal at zero", {63'd0, matchFabric}, 64'd1);
    waitTo(t0 + 130);
    rd(4'd0, 8'h01, "R7 incremented past zero match");
    chk(!matchFabric, "R7 pins low after increment", {63'd0, matchFabric}, 64'd0);

    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R10 all reads returned", 64'(expQ.size()), 64'd0);
    summary();
    $finish;
  end
endmodule